// File: doc/BRIEF.md
# Reply Replay History Buffer

This block remembers the last few reply packets that a control endpoint sent, so that a reply lost on the way to the host can be sent again. Each complete reply arrives as a stream of 32-bit words. It is closed by a separate end strobe that carries the reply's 16-bit packet identifier and a flag saying whether it answered a control packet. Only non-empty control replies that fit in one slot are kept. Each new entry takes the place of the oldest one.

When a resend request arrives with a packet identifier, the buffer looks through its entries from newest to oldest. If one carries that identifier, its words go out again in their original order, one per cycle, and the final word is marked. If none carries it, the output stays quiet. Every request also raises a one-cycle trace record with a fixed resend code, whether or not it matched. That record feeds a traffic log kept elsewhere. The block does not build replies, check identifiers or move packets on a network.

Top module: `reply_history_buf`

## Requirements
- R1: After reset no entry is held: `rp_valid` and `trc_valid` are low, and a request for any identifier, including 0, replays nothing.
- R2: A reply whose end strobe (`cap_done`) has `cap_ctrl`=1, and which had 1 to MAX_WORDS words before the strobe, is stored under the `cap_id` presented with the strobe.
- R3: A reply ended with `cap_ctrl`=0, or with no words, is not stored and does not displace any held entry.
- R4: A reply with more than MAX_WORDS words is not stored.
- R5: At most DEPTH entries are held. Storing one more discards the oldest, and its identifier no longer matches.
- R6: When several held entries carry the requested identifier, the most recently stored one is replayed.
- R7: A request whose identifier matches no held entry replays nothing.
- R8: On a match, `rp_valid` rises in the cycle after the request and stays high for exactly the stored word count. The words come out in the order they arrived, one per cycle, with `rp_last` high only on the final word, and `rp_valid` falls right after it.
- R9: Every request, whether it matches, misses or comes during a replay, gives `trc_valid`=1 with `trc_code`=4 in the following cycle.
- R10: A request that arrives while a replay is running does not interrupt or change that replay.
- R11: A word presented with `cap_valid` in the same cycle as `cap_done` is ignored.
- R12: Capturing and storing new replies during a replay does not change the words being replayed. This holds even when the entry being replayed is the one that the new store discards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | A reply word is present on `cap_data` |
| cap_data | input | 32 | Reply word being captured |
| cap_done | input | 1 | End-of-reply strobe |
| cap_ctrl | input | 1 | With `cap_done`: the reply answered a control packet |
| cap_id | input | 16 | With `cap_done`: packet identifier of the reply |
| rs_req | input | 1 | Resend request strobe |
| rs_id | input | 16 | Packet identifier requested |
| rp_valid | output | 1 | A replayed word is on `rp_data` |
| rp_data | output | 32 | Replayed reply word |
| rp_last | output | 1 | Final word of the replay |
| trc_valid | output | 1 | One-cycle traffic record |
| trc_code | output | 4 | Traffic record code, 4 for a resend request |

## Verification
The hardest case to reach is R12. A request must hit the oldest entry in the same cycle that a new reply commits and discards it. The next reply's words must then be written into the very slot still being read. The bench first fills the history so that a chosen short entry becomes the oldest. It then drives the end strobe of one reply and the resend request in the same cycle, and streams a second reply's words while the replay is still going. Afterwards it checks the replayed words, both new entries and the miss on the discarded identifier.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

  typedef enum logic {
    RP_IDLE = 1'b0,
    RP_PLAY = 1'b1
  } replay_state_e;

  localparam logic [3:0] TRACE_RESEND = 4'd4;

  // a finished reply is kept only for control packets that carried words and fit
  function automatic logic keep_reply(input logic is_ctrl, input logic nonempty,
                                      input logic overflowed);
    return is_ctrl && nonempty && !overflowed;
  endfunction

  // true when a zero-based position is the final one of a run of len items
  function automatic logic is_final(input int pos, input int len);
    return (pos + 1) == len;
  endfunction

endpackage

// File: rtl/rhb_capture.sv
module rhb_capture #(
  parameter int MAXW = 16,
  parameter int LW   = 5,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic          cap_done,
  input  logic          cap_ctrl,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          commit_ev,
  output logic          drop_ev,
  output logic [LW-1:0] commit_len
);
  logic [LW-1:0] cnt;
  logic          ovf;
  logic          word_in;

  assign word_in    = cap_valid && !cap_done;
  assign wr_en      = word_in && !ovf && (cnt < LW'(MAXW));
  assign wr_addr    = cnt[AW-1:0];
  assign commit_ev  = cap_done && rhb_pkg::keep_reply(cap_ctrl, cnt != '0, ovf);
  assign drop_ev    = cap_done && !commit_ev;
  assign commit_len = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (cap_done) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (word_in) begin
      if (cnt == LW'(MAXW)) ovf <= 1'b1;
      else                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rhb_order.sv
module rhb_order #(
  parameter int DEPTH = 4,
  parameter int IDW   = 16,
  parameter int LW    = 5,
  parameter int PW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit_ev,
  input  logic [LW-1:0]  commit_len,
  input  logic [IDW-1:0] commit_tag,
  input  logic [IDW-1:0] look_id,
  output logic [PW-1:0]  scratch_phys,
  output logic           hit,
  output logic [PW-1:0]  hit_phys,
  output logic [LW-1:0]  hit_len
);
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // position 0 is the newest entry, DEPTH-1 the oldest
  logic [PW-1:0]  ord   [DEPTH];
  logic [IDW-1:0] tag   [DEPTH];
  logic [LW-1:0]  len_q [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]  spare;
  logic [QW-1:0]  pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ord[i]   <= PW'(i);
        tag[i]   <= '0;
        len_q[i] <= '0;
      end
      vld   <= '0;
      spare <= PW'(DEPTH);
    end else if (commit_ev) begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        ord[i]   <= ord[i-1];
        tag[i]   <= tag[i-1];
        len_q[i] <= len_q[i-1];
      end
      ord[0]   <= spare;
      tag[0]   <= commit_tag;
      len_q[0] <= commit_len;
      vld      <= {vld[DEPTH-2:0], 1'b1};
      spare    <= ord[DEPTH-1];
    end
  end

  // newest-first search: lower positions overwrite higher ones
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[i] && (tag[i] == look_id)) begin
        hit  = 1'b1;
        pick = QW'(i);
      end
    end
  end

  assign scratch_phys = spare;
  assign hit_phys     = ord[pick];
  assign hit_len      = len_q[pick];
endmodule

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int PHYS = 5,
  parameter int MAXW = 16,
  parameter int DW   = 32,
  parameter int PW   = 3,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_phys,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_phys,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot_q [PHYS];

  for (genvar g = 0; g < PHYS; g++) begin : g_slot
    logic [DW-1:0] words [MAXW];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_phys == PW'(g))) words[wr_addr] <= wr_data;
    end
    assign slot_q[g] = words[rd_addr];
  end

  always_comb begin
    rd_data = slot_q[0];
    for (int i = 1; i < PHYS; i++) begin
      if (rd_phys == PW'(i)) rd_data = slot_q[i];
    end
  end
endmodule

// File: rtl/rhb_replay.sv
module rhb_replay #(
  parameter int LW = 5,
  parameter int AW = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          hit,
  input  logic [PW-1:0] hit_phys,
  input  logic [LW-1:0] hit_len,
  output logic [PW-1:0] rd_phys,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          last,
  output logic          accept_ev
);
  rhb_pkg::replay_state_e st;
  logic [LW-1:0] idx;
  logic [LW-1:0] len;
  logic [PW-1:0] slot;

  assign busy      = (st == rhb_pkg::RP_PLAY);
  assign accept_ev = req && !busy && hit;
  assign last      = busy && rhb_pkg::is_final(int'(idx), int'(len));
  assign rd_phys   = slot;
  assign rd_addr   = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= rhb_pkg::RP_IDLE;
      idx  <= '0;
      len  <= '0;
      slot <= '0;
    end else if (accept_ev) begin
      st   <= rhb_pkg::RP_PLAY;
      idx  <= '0;
      len  <= hit_len;
      slot <= hit_phys;
    end else if (busy) begin
      if (last) st <= rhb_pkg::RP_IDLE;
      else      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/reply_history_buf.sv
module reply_history_buf #(
  parameter int DEPTH     = 4,
  parameter int MAX_WORDS = 16,
  parameter int DW        = 32,
  parameter int IDW       = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_valid,
  input  logic [DW-1:0]  cap_data,
  input  logic           cap_done,
  input  logic           cap_ctrl,
  input  logic [IDW-1:0] cap_id,
  input  logic           rs_req,
  input  logic [IDW-1:0] rs_id,
  output logic           rp_valid,
  output logic [DW-1:0]  rp_data,
  output logic           rp_last,
  output logic           trc_valid,
  output logic [3:0]     trc_code
);
  localparam int PHYS = DEPTH + 1;
  localparam int PW   = $clog2(PHYS);
  localparam int LW   = $clog2(MAX_WORDS + 1);
  localparam int AW   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          commit_ev;
  logic          drop_ev;
  logic [LW-1:0] commit_len;
  logic [PW-1:0] scratch_phys;
  logic          hit;
  logic [PW-1:0] hit_phys;
  logic [LW-1:0] hit_len;
  logic [PW-1:0] rd_phys;
  logic [AW-1:0] rd_addr;
  logic          busy;
  logic          accept_ev;

  rhb_capture #(.MAXW(MAX_WORDS), .LW(LW), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_done(cap_done),
    .cap_ctrl(cap_ctrl), .wr_en(wr_en), .wr_addr(wr_addr),
    .commit_ev(commit_ev), .drop_ev(drop_ev), .commit_len(commit_len)
  );

  rhb_order #(.DEPTH(DEPTH), .IDW(IDW), .LW(LW), .PW(PW)) u_ord (
    .clk(clk), .rst_n(rst_n), .commit_ev(commit_ev), .commit_len(commit_len),
    .commit_tag(cap_id), .look_id(rs_id), .scratch_phys(scratch_phys),
    .hit(hit), .hit_phys(hit_phys), .hit_len(hit_len)
  );

  rhb_store #(.PHYS(PHYS), .MAXW(MAX_WORDS), .DW(DW), .PW(PW), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_phys(scratch_phys), .wr_addr(wr_addr),
    .wr_data(cap_data), .rd_phys(rd_phys), .rd_addr(rd_addr), .rd_data(rp_data)
  );

  rhb_replay #(.LW(LW), .AW(AW), .PW(PW)) u_rep (
    .clk(clk), .rst_n(rst_n), .req(rs_req), .hit(hit), .hit_phys(hit_phys),
    .hit_len(hit_len), .rd_phys(rd_phys), .rd_addr(rd_addr), .busy(busy),
    .last(rp_last), .accept_ev(accept_ev)
  );

  assign rp_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trc_valid <= 1'b0;
      trc_code  <= 4'd0;
    end else begin
      trc_valid <= rs_req;
      trc_code  <= rs_req ? rhb_pkg::TRACE_RESEND : 4'd0;
    end
  end
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int MAX_WORDS = 16,
  parameter int LW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_done,
  input logic          cap_ctrl,
  input logic          rs_req,
  input logic          rp_valid,
  input logic          rp_last,
  input logic          trc_valid,
  input logic [3:0]    trc_code,
  input logic          commit_ev,
  input logic          drop_ev,
  input logic          hit,
  input logic [LW-1:0] hit_len,
  input logic          accept_ev
);
  assert_last_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_last |-> rp_valid);

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && !rp_last |=> rp_valid);

  assert_stream_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_last |=> !rp_valid);

  assert_trace_each_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rs_req |=> trc_valid && (trc_code == 4'd4));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_req && !hit && !rp_valid |=> !rp_valid);

  assert_hit_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> rp_valid);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid |-> !accept_ev);

  assert_data_only_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && !cap_ctrl |-> drop_ev && !commit_ev);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_ev, drop_ev}));

  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_len != '0) && (hit_len <= LW'(MAX_WORDS)));
endmodule

bind reply_history_buf rhb_checker #(.MAX_WORDS(MAX_WORDS), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .cap_ctrl(cap_ctrl),
  .rs_req(rs_req), .rp_valid(rp_valid), .rp_last(rp_last),
  .trc_valid(trc_valid), .trc_code(trc_code), .commit_ev(commit_ev),
  .drop_ev(drop_ev), .hit(hit), .hit_len(hit_len), .accept_ev(accept_ev)
);

// File: tb/sim_reply_history_buf.sv
module sim_reply_history_buf;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_data = '0;
  logic        cap_done = 1'b0;
  logic        cap_ctrl = 1'b0;
  logic [15:0] cap_id = '0;
  logic        rs_req = 1'b0;
  logic [15:0] rs_id = '0;
  logic        rp_valid;
  logic [31:0] rp_data;
  logic        rp_last;
  logic        trc_valid;
  logic [3:0]  trc_code;

  int n_checks = 0;
  int n_fail   = 0;

  always #(PERIOD/2) clk = ~clk;

  reply_history_buf u0 (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_done(cap_done), .cap_ctrl(cap_ctrl), .cap_id(cap_id),
    .rs_req(rs_req), .rs_id(rs_id), .rp_valid(rp_valid), .rp_data(rp_data),
    .rp_last(rp_last), .trc_valid(trc_valid), .trc_code(trc_code)
  );

  typedef struct packed {
    logic [15:0] id;
    logic        ctrl;
    logic [7:0]  n;
    logic [31:0] base;
    logic [15:0] rid;
    logic [7:0]  elen;
    logic [31:0] ebase;
    logic [7:0]  req;
  } vec_t;

  // capture one reply, then request rid; elen 0 means no replay expected
  localparam vec_t TBL [10] = '{
    '{16'd10, 1'b1, 8'd3,  32'h1000, 16'd10, 8'd3,  32'h1000, 8'd2},
    '{16'd11, 1'b0, 8'd2,  32'h2000, 16'd11, 8'd0,  32'h0,    8'd3},
    '{16'd12, 1'b1, 8'd0,  32'h0,    16'd12, 8'd0,  32'h0,    8'd3},
    '{16'd13, 1'b1, 8'd16, 32'h3000, 16'd13, 8'd16, 32'h3000, 8'd2},
    '{16'd14, 1'b1, 8'd17, 32'h3800, 16'd14, 8'd0,  32'h0,    8'd4},
    '{16'd15, 1'b1, 8'd1,  32'h4000, 16'd15, 8'd1,  32'h4000, 8'd8},
    '{16'd16, 1'b1, 8'd2,  32'h5000, 16'd10, 8'd3,  32'h1000, 8'd5},
    '{16'd17, 1'b1, 8'd2,  32'h6000, 16'd10, 8'd0,  32'h0,    8'd5},
    '{16'd16, 1'b1, 8'd5,  32'h7000, 16'd16, 8'd5,  32'h7000, 8'd6},
    '{16'd18, 1'b0, 8'd3,  32'hC000, 16'd15, 8'd1,  32'h4000, 8'd3}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic send_reply(input logic [15:0] id, input logic ctrl, input int n,
                            input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      cap_valid = 1'b1;
      cap_data  = base + 32'(k);
      @(negedge clk);
    end
    cap_valid = 1'b0;
    cap_done  = 1'b1;
    cap_id    = id;
    cap_ctrl  = ctrl;
    @(negedge clk);
    cap_done  = 1'b0;
  endtask

  task automatic request(input logic [15:0] id, input int elen, input logic [31:0] ebase,
                         input string req);
    rs_req = 1'b1;
    rs_id  = id;
    @(negedge clk);
    rs_req = 1'b0;
    check(trc_valid && trc_code == 4'd4, "R9 trace", {27'd0, trc_valid, trc_code}, 32'h14);
    for (int k = 0; k < elen; k++) begin
      check(rp_valid === 1'b1, req, 32'(rp_valid), 32'd1);
      check(rp_data === ebase + 32'(k), req, rp_data, ebase + 32'(k));
      check(rp_last === (k == elen - 1), "R8 last flag", 32'(rp_last), 32'(k == elen - 1));
      @(negedge clk);
    end
    check(rp_valid === 1'b0, req, 32'(rp_valid), 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rp_valid === 1'b0, "R1 rp_valid in reset", 32'(rp_valid), 32'd0);
    check(trc_valid === 1'b0, "R1 trc_valid in reset", 32'(trc_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rp_valid === 1'b0, "R1 rp_valid after reset", 32'(rp_valid), 32'd0);
    request(16'd0, 0, 32'h0, "R1 empty history");
    request(16'd10, 0, 32'h0, "R1 empty history");

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 10; v++) begin
      send_reply(TBL[v].id, TBL[v].ctrl, int'(TBL[v].n), TBL[v].base);
      request(TBL[v].rid, int'(TBL[v].elen), TBL[v].ebase,
              $sformatf("R%0d row %0d", TBL[v].req, v));
    end

    // R10: request during a replay of id 16 (newest copy, 5 words)
    rs_req = 1'b1; rs_id = 16'd16;
    @(negedge clk);
    rs_req = 1'b0;
    check(rp_data === 32'h7000, "R10 word0", rp_data, 32'h7000);
    @(negedge clk);
    check(rp_data === 32'h7001, "R10 word1", rp_data, 32'h7001);
    rs_req = 1'b1; rs_id = 16'd15;
    @(negedge clk);
    rs_req = 1'b0;
    check(trc_valid === 1'b1, "R9 trace during replay", 32'(trc_valid), 32'd1);
    for (int k = 2; k < 5; k++) begin
      check(rp_valid === 1'b1 && rp_data === 32'h7000 + 32'(k), "R10 continues",
            rp_data, 32'h7000 + 32'(k));
      @(negedge clk);
    end
    check(rp_valid === 1'b0, "R10 no second replay", 32'(rp_valid), 32'd0);

    // R11: a word beside the end strobe is dropped
    cap_valid = 1'b1; cap_data = 32'hA000; @(negedge clk);
    cap_data = 32'hA001; @(negedge clk);
    cap_data = 32'hAFFF; cap_done = 1'b1; cap_id = 16'd20; cap_ctrl = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0; cap_done = 1'b0;
    request(16'd20, 2, 32'hA000, "R11 length unchanged");

    // R12: make id 17 the oldest, then replay it while it is discarded and reused
    send_reply(16'd23, 1'b1, 3, 32'hB000);
    cap_valid = 1'b1; cap_data = 32'h8000; @(negedge clk);
    cap_data = 32'h8001; @(negedge clk);
    cap_valid = 1'b0; cap_done = 1'b1; cap_id = 16'd24; cap_ctrl = 1'b1;
    rs_req = 1'b1; rs_id = 16'd17;
    @(negedge clk);
    cap_done = 1'b0; rs_req = 1'b0;
    cap_valid = 1'b1; cap_data = 32'h9000;
    check(rp_valid === 1'b1 && rp_data === 32'h6000, "R12 word0", rp_data, 32'h6000);
    @(negedge clk);
    cap_data = 32'h9001;
    check(rp_last === 1'b1 && rp_data === 32'h6001, "R12 word1", rp_data, 32'h6001);
    @(negedge clk);
    cap_valid = 1'b0;
    check(rp_valid === 1'b0, "R12 end", 32'(rp_valid), 32'd0);
    cap_done = 1'b1; cap_id = 16'd25; cap_ctrl = 1'b1;
    @(negedge clk);
    cap_done = 1'b0;
    request(16'd24, 2, 32'h8000, "R12 concurrent store");
    request(16'd25, 2, 32'h9000, "R12 reused slot");
    request(16'd17, 0, 32'h0, "R5 discarded id");

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule